// File: doc/BRIEF.md
# Block-Move DMA Engine

This block moves a run of words between one peripheral and memory without help from the processor. Software sets up three configuration registers: a start word address, a word count and a direction bit. It then writes a go bit. From then on the engine drives memory as a bus master and paces each word with a request/acknowledge exchange toward the peripheral. When the last word has moved it raises a level interrupt, which software clears by writing one to the done bit.

Memory accesses wait for `mem_ack`. Each word is a single memory access, and the address advances by one word after each word. In the device-to-memory direction the engine first takes a word from the peripheral, then writes it to memory. It acknowledges the peripheral only after memory has accepted the write. In the memory-to-device direction the engine reads memory, holds the word on `dev_dout`, and hands it over when the peripheral signals ready.

Top module: `dmac_top`

## Requirements
- R1: After reset, `irq`, `mem_req` and `dev_ack` are 0, and the status register (offset 3) reads 0.
- R2: The register port decodes four offsets. Offset 0 holds the start address, offset 1 holds the word count, and bit 0 of offset 2 holds the direction. Each reads back the value last written. Offset 3 reads busy in bit 0 and done in bit 1.
- R3: Writing offset 2 with bit 1 set while idle starts a transfer. The transfer uses the programmed address, count and direction, and clears done. Busy reads 1 from the cycle after that write until the transfer ends, and `mem_req` is only ever high while busy.
- R4: Direction 0 (device to memory). A memory write (`mem_we`=1) starts only after `dev_req` was seen high with a word on `dev_din`. Word i lands at address start+i, modulo the address width. `dev_ack` follows the accepted write.
- R5: Direction 1 (memory to device). Word i is read from address start+i. It is presented on `dev_dout` in the cycle `dev_ack` is high.
- R6: The address steps by one after each word. Exactly count memory accesses take place.
- R7: While `mem_req` is high and `mem_ack` is low, the request, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R8: When the last word is acknowledged, done becomes 1, busy becomes 0 and `irq` goes high.
- R9: Writing offset 3 with bit 1 set clears done and `irq`. Writing it with bit 1 clear leaves them set.
- R10: While busy, writes to offsets 0, 1 and 2 have no effect. This includes a second go.
- R11: A go with a count of 0 sets done without any `mem_req` or `dev_ack`.
- R12: `dev_ack` is high for exactly one cycle per word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion interrupt, level, equals done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Access accepted / read data valid |
| mem_rdata | input | DW | Memory read data |
| dev_req | input | 1 | Peripheral has a word (dir 0) or is ready (dir 1) |
| dev_din | input | DW | Word from the peripheral |
| dev_ack | output | 1 | One-cycle word handover pulse |
| dev_dout | output | DW | Word to the peripheral |

## Verification
The hardest case to reach from the ports is a register write that arrives during a live transfer: the write must leave both the readback and the moving transfer untouched. The bench slows the peripheral with stall cycles so that busy stays high long enough. It then writes new values, including a fresh go, and reads the registers back. Afterwards it checks that the access count and the memory contents still match the original setup. Address wrap-around is reached by sweeping start addresses near the top of an 8-bit space, across word counts, memory wait states and device stalls.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_GET  = 3'd1,
        S_WR   = 3'd2,
        S_RD   = 3'd3,
        S_PUT  = 3'd4,
        S_ACK  = 3'd5
    } eng_state_e;

    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_LEN  = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_busy,
    input  logic          eng_done,
    output logic [AW-1:0] cfg_addr,
    output logic [CW-1:0] cfg_len,
    output logic          cfg_dir,
    output logic          go,
    output logic          busy,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] len;
        logic          dir;
        logic          go;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    assign busy = eng_busy | r_q.go;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        if (reg_we && !busy) begin
            case (reg_addr)
                OFS_ADDR: r_d.addr = reg_wdata[AW-1:0];
                OFS_LEN:  r_d.len  = reg_wdata[CW-1:0];
                OFS_CTRL: begin
                    r_d.dir = reg_wdata[CTRL_DIR_BIT];
                    r_d.go  = reg_wdata[CTRL_GO_BIT];
                    if (reg_wdata[CTRL_GO_BIT]) r_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        if (reg_we && reg_addr == OFS_STAT && reg_wdata[STAT_DONE_BIT])
            r_d.done = 1'b0;
        if (eng_done)
            r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_ADDR: reg_rdata = DW'(r_q.addr);
            OFS_LEN:  reg_rdata = DW'(r_q.len);
            OFS_CTRL: reg_rdata = DW'(r_q.dir);
            default:  reg_rdata = DW'({r_q.done, busy});
        endcase
    end

    assign cfg_addr = r_q.addr;
    assign cfg_len  = r_q.len;
    assign cfg_dir  = r_q.dir;
    assign go       = r_q.go;
    assign irq      = r_q.done;

    // R10: configuration frozen while a transfer runs
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr != OFS_STAT) |=>
            ($stable(cfg_addr) && $stable(cfg_len) && $stable(cfg_dir) && !go));

    // R9: the interrupt only falls after a clearing write
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && reg_wdata[STAT_DONE_BIT] &&
                             (reg_addr == OFS_STAT || reg_addr == OFS_CTRL)));
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_len,
    input  logic          cfg_dir,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_req,
    input  logic [DW-1:0] dev_din,
    output logic          dev_ack,
    output logic [DW-1:0] dev_dout,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);
    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          dir;
        logic [DW-1:0] dbuf;
        logic          done;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        case (e_q.state)
            S_IDLE: if (go) begin
                if (cfg_len == '0) begin
                    e_d.done = 1'b1;
                end else begin
                    e_d.addr  = cfg_addr;
                    e_d.cnt   = cfg_len;
                    e_d.dir   = cfg_dir;
                    e_d.state = cfg_dir ? S_RD : S_GET;
                end
            end
            S_GET: if (dev_req) begin
                e_d.dbuf  = dev_din;
                e_d.state = S_WR;
            end
            S_WR: if (mem_ack) e_d.state = S_ACK;
            S_RD: if (mem_ack) begin
                e_d.dbuf  = mem_rdata;
                e_d.state = S_PUT;
            end
            S_PUT: if (dev_req) e_d.state = S_ACK;
            S_ACK: begin
                e_d.addr = e_q.addr + ADDR_STEP;
                e_d.cnt  = e_q.cnt - CNT_LAST;
                if (e_q.cnt == CNT_LAST) begin
                    e_d.state = S_IDLE;
                    e_d.done  = 1'b1;
                end else begin
                    e_d.state = e_q.dir ? S_RD : S_GET;
                end
            end
            default: e_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_req   = (e_q.state == S_WR) || (e_q.state == S_RD);
    assign mem_we    = (e_q.state == S_WR);
    assign mem_addr  = e_q.addr;
    assign mem_wdata = e_q.dbuf;
    assign dev_dout  = e_q.dbuf;
    assign dev_ack   = (e_q.state == S_ACK);
    assign busy      = (e_q.state != S_IDLE);
    assign done      = e_q.done;

    // R7: an unanswered request holds its attributes
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12: handover pulse lasts one cycle
    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> !dev_ack);

    // R6: address advances by one per word
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> (mem_addr == $past(mem_addr) + ADDR_STEP));

    // R4: a memory write only follows a peripheral word
    p_wr_after_dev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> $past(dev_req));

    // R11: zero count finishes without entering a transfer
    p_zero_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && cfg_len == '0) |=> (done && !busy));

    // R8: completion leaves the engine idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_req,
    input  logic [DW-1:0] dev_din,
    output logic          dev_ack,
    output logic [DW-1:0] dev_dout
);
    logic [AW-1:0] cfg_addr;
    logic [CW-1:0] cfg_len;
    logic          cfg_dir;
    logic          go;
    logic          busy;
    logic          eng_busy;
    logic          eng_done;

    dmac_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_dir(cfg_dir),
        .go(go), .busy(busy), .irq(irq)
    );

    dmac_engine #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(go), .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_dir(cfg_dir),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_din(dev_din), .dev_ack(dev_ack), .dev_dout(dev_dout),
        .busy(eng_busy), .done(eng_done)
    );

    // R3: memory traffic only while the status shows busy
    p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

// File: tb/sim_dmac_top.sv
module sim_dmac_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int DW = 16;
    localparam logic [DW-1:0] FILL = 16'hDEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic dev_req = 1'b0;
    logic [DW-1:0] dev_din = '0;
    logic dev_ack;
    logic [DW-1:0] dev_dout;

    int n_cmp = 0;
    int n_bad = 0;

    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] sink [0:15];
    int mem_wait = 0, wcnt = 0, acc_cnt = 0;
    int dev_stall = 0, dev_idx = 0, dev_total = 0, tick = 0, ack_cnt = 0;
    logic dev_on = 1'b0, dev_sink = 1'b0;

    dmac_top #(.AW(AW), .CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_din(dev_din), .dev_ack(dev_ack), .dev_dout(dev_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return DW'(16'hA500 ^ (i * 37 + salt * 11));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= mem_wait) begin
                    mem_ack = 1'b1;
                    acc_cnt++;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem[mem_addr];
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // peripheral model
    initial begin
        forever begin
            @(negedge clk);
            tick++;
            if (dev_ack) begin
                ack_cnt++;
                if (dev_sink && dev_idx < 16) sink[dev_idx] = dev_dout;
                dev_idx++;
            end
            dev_req = dev_on && (dev_idx < dev_total) && ((tick % (dev_stall + 1)) == 0);
            dev_din = pat(dev_idx, dev_total);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

    task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
    endtask

    task automatic run_xfer(input bit dir, input logic [AW-1:0] base, input int len,
                            input int mw, input int ds);
        logic [DW-1:0] st;
        logic [AW-1:0] a;
        for (int i = 0; i < 256; i++) mem[i] = dir ? pat(i, 3) : FILL;
        mem_wait = mw; dev_stall = ds; acc_cnt = 0; ack_cnt = 0;
        dev_idx = 0; dev_total = len; dev_sink = dir; dev_on = 1'b1;
        wr_reg(2'd0, DW'(base));
        wr_reg(2'd1, DW'(len));
        wr_reg(2'd2, DW'({1'b1, dir}));
        wait_irq();
        check(irq == 1'b1, "R8 irq", irq, 1);
        rd_reg(2'd3, st);
        check(st[1:0] == 2'b10, "R8 status", st, 2);
        check(acc_cnt == len, "R6 access count", acc_cnt, len);
        check(ack_cnt == len, "R12 ack count", ack_cnt, len);
        if (len == 0) check(acc_cnt == 0 && ack_cnt == 0, "R11 zero quiet", acc_cnt + ack_cnt, 0);
        for (int i = 0; i < len; i++) begin
            a = AW'(int'(base) + i);
            if (dir) check(sink[i] == mem[a], "R5 word", sink[i], mem[a]);
            else     check(mem[a] == pat(i, len), "R4 word", mem[a], pat(i, len));
        end
        if (!dir) begin
            a = AW'(int'(base) + len);
            if (len < 15) check(mem[a] == FILL, "R6 no overrun", mem[a], FILL);
        end
        dev_on = 1'b0;
        wr_reg(2'd3, DW'(2));
        check(irq == 1'b0, "R9 cleared", irq, 0);
    endtask

    initial begin
        logic [DW-1:0] v;
        int lens [6] = '{0, 1, 2, 3, 5, 15};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd3, v);
        check(v == '0 && !irq && !mem_req && !dev_ack, "R1 reset", v, 0);

        // R2 readback
        wr_reg(2'd0, DW'(8'h5A));
        wr_reg(2'd1, DW'(4'h9));
        wr_reg(2'd2, DW'(1));
        rd_reg(2'd0, v); check(v == DW'(8'h5A), "R2 addr", v, 8'h5A);
        rd_reg(2'd1, v); check(v == DW'(4'h9), "R2 len", v, 9);
        rd_reg(2'd2, v); check(v == DW'(1), "R2 dir", v, 1);
        rd_reg(2'd3, v); check(v == '0, "R2 status idle", v, 0);

        // sweep
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 6; l++)
                for (int mw = 0; mw < 3; mw++)
                    for (int ds = 0; ds < 2; ds++)
                        run_xfer(d[0], AW'(lens[l] * 17 + mw * 40 + 250 * d), lens[l], mw, ds);

        // R9 writing zero to done keeps it
        run_xfer(1'b0, 8'h10, 1, 0, 0);
        wr_reg(2'd1, DW'(0));
        wr_reg(2'd2, DW'(2));
        wait_irq();
        wr_reg(2'd3, DW'(1));
        check(irq == 1'b1, "R9 zero write keeps irq", irq, 1);
        wr_reg(2'd3, DW'(2));
        check(irq == 1'b0, "R9 clear", irq, 0);

        // R10 writes while busy, R3 busy visible
        for (int i = 0; i < 256; i++) mem[i] = FILL;
        mem_wait = 1; dev_stall = 4; acc_cnt = 0; ack_cnt = 0;
        dev_idx = 0; dev_total = 4; dev_sink = 1'b0; dev_on = 1'b1;
        wr_reg(2'd0, DW'(8'h40));
        wr_reg(2'd1, DW'(4));
        wr_reg(2'd2, DW'(2));
        rd_reg(2'd3, v); check(v[0] == 1'b1, "R3 busy", v, 1);
        wr_reg(2'd0, DW'(8'hF0));
        wr_reg(2'd1, DW'(9));
        wr_reg(2'd2, DW'(3));
        rd_reg(2'd0, v); check(v == DW'(8'h40), "R10 addr held", v, 8'h40);
        rd_reg(2'd1, v); check(v == DW'(4), "R10 len held", v, 4);
        rd_reg(2'd2, v); check(v == '0, "R10 dir held", v, 0);
        wait_irq();
        repeat (20) @(negedge clk);
        check(acc_cnt == 4, "R10 no restart", acc_cnt, 4);
        for (int i = 0; i < 4; i++)
            check(mem[8'h40 + i] == pat(i, 4), "R10 data", mem[8'h40 + i], pat(i, 4));
        check(mem[8'hF0] == FILL, "R10 stray addr", mem[8'hF0], FILL);
        dev_on = 1'b0;

        summary();
        $finish;
    end
endmodule